// File: doc/BRIEF.md
# Queued-Op SPI Master

This block is a single-lane SPI master. Software does not start a transfer from a start/length register. It builds each SPI transaction as a short script of operation words and queues them. Each word pairs an op code with a byte count. One op drives chip select low, one drives it high, one shifts bytes out and one collects bytes in. The engine takes one word at a time from a 16-entry op queue and runs it to completion before it takes the next.

Payload goes through one shared 16-entry byte queue. Software writes transmit bytes into it. The engine drains those bytes during a transmit op and fills the same queue during a receive op. Software then reads the received bytes at the head and pops them with a strobe. Each queue reports full and empty, and software paces every access on those flags. The bus interface is SPI mode 0: SCK idles low, the master samples MISO on the rising edge and changes MOSI on the falling edge, and bytes go most significant bit first. The SCK rate is a programmable divide of the system clock.

Top module: `spi_opq_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, both queues report empty and not full, and err_flag is 0.
- R2: While man_en is 0, op_push is ignored: op_empty stays 1 and no pin changes.
- R3: An op word is {code[13:9], count[8:0]}. Code 5'h01 drives spi_cs_n to 0 and code 5'h00 drives it to 1, whatever the count.
- R4: Code 5'h08 with count N sends N bytes taken from the byte queue in queue order, MSB first. MOSI never changes in the system cycle in which SCK rises.
- R5: Code 5'h0C with count N samples N bytes from MISO on rising SCK edges, MSB first, and appends them to the byte queue. rx_rdata shows the head byte and rx_pop removes it.
- R6: SCK is high for max(clk_div,1) system cycles and low for the same number of cycles within a byte, so the shortest SCK period is 2 cycles.
- R7: A transmit or receive op with count 0 is consumed without any SCK pulse.
- R8: During a transmit op with an empty byte queue, SCK stays low and the op stays active. It resumes when a byte is written.
- R9: An op code other than 00, 01, 08 or 0C is consumed with no pin activity and sets err_flag, which then stays 1 until reset.
- R10: Each queue holds 16 entries. Its full flag rises after the 16th accepted write, a write while full is dropped, and entries leave in write order.
- R11: A single op moves up to 511 bytes. During a receive op the engine stalls SCK while the byte queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_en | input | 1 | Enables op acceptance and execution |
| clk_div | input | 8 | SCK half-period in system cycles (0 acts as 1) |
| op_wdata | input | 14 | Op word: code [13:9], byte count [8:0] |
| op_push | input | 1 | Writes op_wdata into the op queue |
| op_full | output | 1 | Op queue full |
| op_empty | output | 1 | Op queue empty |
| tx_wdata | input | 8 | Byte to append to the byte queue |
| tx_push | input | 1 | Writes tx_wdata into the byte queue |
| rx_pop | input | 1 | Removes the head byte |
| rx_rdata | output | 8 | Head byte of the byte queue |
| dq_full | output | 1 | Byte queue full |
| dq_empty | output | 1 | Byte queue empty |
| err_flag | output | 1 | Sticky unknown-op flag |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The byte-queue room assertion assumes software never writes transmit bytes while a receive op is active. The engine reserves room for a received byte only when that byte starts, so a concurrent write could take the slot. The bench writes bytes only before or during transmit ops, and it drains the queue during the long receive. The chip-select assertion assumes no op word arrives while man_en is low. The bench drives man_en low only during the reset and gating checks. A bench-side SPI slave model returns an arithmetic byte pattern, so all expected receive data comes from the count of SCK edges.

// File: rtl/spi_opq_master.sv
module spi_opq_master #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 9,
  parameter int CODE_W = 5,
  parameter int DIV_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    man_en,
  input  logic [DIV_W-1:0]        clk_div,
  input  logic [CODE_W+CNT_W-1:0] op_wdata,
  input  logic                    op_push,
  output logic                    op_full,
  output logic                    op_empty,
  input  logic [7:0]              tx_wdata,
  input  logic                    tx_push,
  input  logic                    rx_pop,
  output logic [7:0]              rx_rdata,
  output logic                    dq_full,
  output logic                    dq_empty,
  output logic                    err_flag,
  output logic                    spi_sck,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);

  localparam int AW  = $clog2(DEPTH);
  localparam int LW  = AW + 1;
  localparam int OPW = CODE_W + CNT_W;
  localparam logic [CODE_W-1:0] OP_CSH = CODE_W'(0);
  localparam logic [CODE_W-1:0] OP_CSL = CODE_W'(1);
  localparam logic [CODE_W-1:0] OP_TX  = CODE_W'(8);
  localparam logic [CODE_W-1:0] OP_RX  = CODE_W'(12);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} st_t;

  logic [OPW-1:0]    oq_mem [DEPTH];
  logic [AW-1:0]     oq_wp, oq_rp;
  logic [LW-1:0]     oq_n;
  logic [7:0]        dq_mem [DEPTH];
  logic [AW-1:0]     dq_wp, dq_rp;
  logic [LW-1:0]     dq_n;

  st_t               st;
  logic              rx_mode;
  logic [CNT_W-1:0]  rem;
  logic [DIV_W-1:0]  tick;
  logic [2:0]        bitn;
  logic [7:0]        tsh, rsh;

  logic [DIV_W-1:0]  hp;
  logic [OPW-1:0]    head;
  logic [CODE_W-1:0] hcode;
  logic [CNT_W-1:0]  hcnt;
  logic              oq_push, op_pop;
  logic              eng_pop, start_rx, edge_t, byte_end, eng_push;
  logic              bus_push, bus_pop, dq_push, dq_pop;
  logic [7:0]        dq_din;

  assign hp       = (clk_div == '0) ? DIV_W'(1) : clk_div;
  assign op_full  = (oq_n == LW'(DEPTH));
  assign op_empty = (oq_n == '0);
  assign dq_full  = (dq_n == LW'(DEPTH));
  assign dq_empty = (dq_n == '0);
  assign rx_rdata = dq_mem[dq_rp];
  assign head     = oq_mem[oq_rp];
  assign hcode    = head[OPW-1:CNT_W];
  assign hcnt     = head[CNT_W-1:0];
  assign spi_mosi = tsh[7];

  assign oq_push  = op_push && man_en && !op_full;
  assign op_pop   = (st == S_IDLE) && man_en && !op_empty;
  assign eng_pop  = (st == S_WAIT) && !rx_mode && !dq_empty;
  assign start_rx = (st == S_WAIT) && rx_mode && !dq_full;
  assign edge_t   = (st == S_SHIFT) && (tick == hp - DIV_W'(1));
  assign byte_end = edge_t && spi_sck && (bitn == 3'd7);
  assign eng_push = byte_end && rx_mode;
  assign bus_push = tx_push && !dq_full && !eng_push;
  assign bus_pop  = rx_pop && !dq_empty && !eng_pop;
  assign dq_push  = eng_push || bus_push;
  assign dq_pop   = eng_pop || bus_pop;
  assign dq_din   = eng_push ? rsh : tx_wdata;

  always_ff @(posedge clk) begin
    if (oq_push) oq_mem[oq_wp] <= op_wdata;
    if (dq_push) dq_mem[dq_wp] <= dq_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oq_wp <= '0; oq_rp <= '0; oq_n <= '0;
      dq_wp <= '0; dq_rp <= '0; dq_n <= '0;
    end else begin
      if (oq_push) oq_wp <= oq_wp + AW'(1);
      if (op_pop)  oq_rp <= oq_rp + AW'(1);
      oq_n <= oq_n + LW'(oq_push) - LW'(op_pop);
      if (dq_push) dq_wp <= dq_wp + AW'(1);
      if (dq_pop)  dq_rp <= dq_rp + AW'(1);
      dq_n <= dq_n + LW'(dq_push) - LW'(dq_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_mode <= 1'b0; rem <= '0; tick <= '0; bitn <= '0;
      tsh <= '0; rsh <= '0; spi_sck <= 1'b0; spi_cs_n <= 1'b1; err_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (op_pop) begin
          case (hcode)
            OP_CSH: spi_cs_n <= 1'b1;
            OP_CSL: spi_cs_n <= 1'b0;
            OP_TX, OP_RX: if (hcnt != '0) begin
              rem     <= hcnt;
              rx_mode <= (hcode == OP_RX);
              st      <= S_WAIT;
            end
            default: err_flag <= 1'b1;
          endcase
        end
        S_WAIT: if (eng_pop || start_rx) begin
          tsh  <= eng_pop ? rx_rdata : 8'h00;
          tick <= '0;
          bitn <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: if (edge_t) begin
          tick <= '0;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rsh     <= {rsh[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            if (bitn == 3'd7) begin
              rem <= rem - CNT_W'(1);
              st  <= (rem == CNT_W'(1)) ? S_IDLE : S_WAIT;
            end else begin
              bitn <= bitn + 3'd1;
              tsh  <= {tsh[6:0], 1'b0};
            end
          end
        end else begin
          tick <= tick + DIV_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  op_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && op_empty) |=> op_empty);

  // R3
  cs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> $past(op_pop));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_pop |-> !spi_sck);

  // R8
  tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAIT) && !rx_mode && dq_empty && !tx_push) |=> (!spi_sck && (st == S_WAIT)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_n <= LW'(DEPTH)) && (dq_n <= LW'(DEPTH)));

  // R11
  dq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_push |-> (!dq_full || bus_pop));

endmodule

// File: tb/spi_opq_master_tb.sv
module spi_opq_master_tb;
  logic clk = 0, rst_n = 0, man_en = 0;
  logic [7:0] clk_div = 0;
  logic [13:0] op_wdata = 0;
  logic op_push = 0, tx_push = 0, rx_pop = 0;
  logic [7:0] tx_wdata = 0;
  logic op_full, op_empty, dq_full, dq_empty, err_flag;
  logic [7:0] rx_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_opq_master u_dut (
    .clk(clk), .rst_n(rst_n), .man_en(man_en), .clk_div(clk_div),
    .op_wdata(op_wdata), .op_push(op_push), .op_full(op_full), .op_empty(op_empty),
    .tx_wdata(tx_wdata), .tx_push(tx_push), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .dq_full(dq_full), .dq_empty(dq_empty), .err_flag(err_flag),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 5);
  endfunction
  function automatic logic pbit(input int i);
    logic [7:0] b;
    b = pat(i / 8);
    return b[7 - (i % 8)];
  endfunction

  // slave model
  int mi = 0, cap_n = 0, cbit = 0;
  logic [7:0] csh = 0;
  logic [7:0] cap [0:2047];
  assign spi_miso = pbit(mi);
  always @(negedge spi_sck) mi <= mi + 1;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    csh = {csh[6:0], spi_mosi};
    cbit++;
    if (cbit == 8) begin cap[cap_n] = csh; cap_n++; cbit = 0; end
  end

  // pin monitor at the quiet edge
  logic p_sck = 0, p_mosi = 0;
  int hi_run = 0, last_hi = 0, rises = 0, mosi_bad = 0;
  always @(negedge clk) begin
    if (spi_sck && !p_sck) begin
      rises++;
      if (spi_mosi !== p_mosi) mosi_bad++;
    end
    if (spi_sck) hi_run++;
    else begin if (p_sck) last_hi = hi_run; hi_run = 0; end
    p_sck = spi_sck; p_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_op(input logic [4:0] c, input logic [8:0] n);
    @(negedge clk); op_wdata = {c, n}; op_push = 1;
    @(negedge clk); op_push = 0;
  endtask
  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); tx_wdata = b; tx_push = 1;
    @(negedge clk); tx_push = 0;
  endtask
  task automatic pop_byte();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask
  task automatic wait_done();
    do @(negedge clk); while (!(op_empty && spi_cs_n));
    repeat (2) @(negedge clk);
  endtask

  task automatic run();
    int base, mbase, r0, bad, got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(spi_cs_n == 1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sck == 0, "R1 sck", spi_sck, 0);
    chk(op_empty && !op_full, "R1 op flags", {op_full, op_empty}, 1);
    chk(dq_empty && !dq_full, "R1 dq flags", {dq_full, dq_empty}, 1);
    chk(err_flag == 0, "R1 err", err_flag, 0);

    // R2
    put_op(5'h01, 9'd1);
    repeat (5) @(negedge clk);
    chk(op_empty == 1, "R2 op dropped", op_empty, 1);
    chk(spi_cs_n == 1, "R2 cs idle", spi_cs_n, 1);

    man_en = 1;
    // R3
    put_op(5'h01, 9'd1); repeat (2) @(negedge clk);
    chk(spi_cs_n == 0, "R3 cs low", spi_cs_n, 0);
    put_op(5'h00, 9'd300); repeat (2) @(negedge clk);
    chk(spi_cs_n == 1, "R3 cs high any count", spi_cs_n, 1);
    put_op(5'h01, 9'd0); repeat (2) @(negedge clk);
    chk(spi_cs_n == 0, "R3 cs low count0", spi_cs_n, 0);
    put_op(5'h00, 9'd1); repeat (2) @(negedge clk);

    // R4 and R6: divider sweep
    for (int d = 0; d < 5; d++) begin
      clk_div = 8'(d);
      base = cap_n;
      for (int j = 0; j < 3; j++) put_byte(8'(d * 50 + j * 7 + 1));
      put_op(5'h01, 9'd1); put_op(5'h08, 9'd3); put_op(5'h00, 9'd1);
      wait_done();
      chk(cap_n - base == 3, "R4 tx byte count", cap_n - base, 3);
      for (int j = 0; j < 3; j++)
        chk(cap[base + j] == 8'(d * 50 + j * 7 + 1), "R4 tx byte", cap[base + j], 8'(d * 50 + j * 7 + 1));
      chk(last_hi == ((d == 0) ? 1 : d), "R6 sck high width", last_hi, (d == 0) ? 1 : d);
    end
    chk(mosi_bad == 0, "R4 mosi at rising edge", mosi_bad, 0);

    // R5
    clk_div = 2;
    mbase = mi;
    put_op(5'h01, 9'd1); put_op(5'h0C, 9'd5); put_op(5'h00, 9'd1);
    wait_done();
    for (int j = 0; j < 5; j++) begin
      chk(rx_rdata == pat(mbase / 8 + j), "R5 rx byte", rx_rdata, pat(mbase / 8 + j));
      pop_byte();
    end
    chk(dq_empty == 1, "R5 drained", dq_empty, 1);

    // R7
    r0 = rises;
    put_op(5'h01, 9'd1); put_op(5'h0C, 9'd0); put_op(5'h08, 9'd0); put_op(5'h00, 9'd1);
    wait_done();
    chk(rises == r0, "R7 no pulses", rises - r0, 0);

    // R8
    clk_div = 1;
    base = cap_n;
    put_op(5'h01, 9'd1); put_op(5'h08, 9'd2); put_byte(8'hA5);
    repeat (60) @(negedge clk);
    chk(cap_n - base == 1, "R8 one byte sent", cap_n - base, 1);
    chk(spi_sck == 0, "R8 sck held low", spi_sck, 0);
    chk(spi_cs_n == 0 && op_empty, "R8 op still active", spi_cs_n, 0);
    put_byte(8'h3C); put_op(5'h00, 9'd1);
    wait_done();
    chk(cap[base + 1] == 8'h3C, "R8 resumed byte", cap[base + 1], 8'h3C);

    // R9
    r0 = rises;
    put_op(5'h05, 9'd3); repeat (10) @(negedge clk);
    chk(err_flag == 1, "R9 err set", err_flag, 1);
    chk(spi_cs_n == 1 && rises == r0, "R9 no pin activity", rises - r0, 0);
    put_op(5'h01, 9'd1); put_op(5'h00, 9'd1); wait_done();
    chk(err_flag == 1, "R9 err sticky", err_flag, 1);

    // R10: byte queue depth and order
    for (int k = 0; k < 17; k++) begin
      put_byte(8'(k * 11 + 3));
      if (k == 15) chk(dq_full == 1, "R10 dq full at 16", dq_full, 1);
    end
    for (int k = 0; k < 16; k++) begin
      chk(rx_rdata == 8'(k * 11 + 3), "R10 dq order", rx_rdata, 8'(k * 11 + 3));
      pop_byte();
    end
    chk(dq_empty == 1, "R10 extra write dropped", dq_empty, 1);
    // R10: op queue depth
    base = cap_n;
    put_op(5'h01, 9'd1); put_op(5'h08, 9'd1);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 16; k++) put_op(5'h00, 9'd1);
    chk(op_full == 1, "R10 op full at 16", op_full, 1);
    put_op(5'h00, 9'd1);
    put_byte(8'h5A);
    wait_done();
    chk(cap[base] == 8'h5A && cap_n - base == 1, "R10 op queue drained", cap[base], 8'h5A);

    // R11: maximum count receive with queue back-pressure
    clk_div = 1;
    mbase = mi; bad = 0; got = 0;
    put_op(5'h01, 9'd1); put_op(5'h0C, 9'h1FF); put_op(5'h00, 9'd1);
    while (got < 511) begin
      @(negedge clk);
      if (rx_pop) rx_pop = 0;
      else if (!dq_empty) begin
        if (rx_rdata != pat(mbase / 8 + got)) bad++;
        got++;
        rx_pop = 1;
      end
    end
    @(negedge clk); rx_pop = 0;
    wait_done();
    chk(bad == 0, "R11 511-byte receive", bad, 0);
    chk(dq_empty == 1, "R11 exact count", dq_empty, 1);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog act=%0d exp=<%0d", 150000, 150000);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule